// File: doc/BRIEF.md
# Interrupt Event Collector with Set/Clear Mask

This block gathers single-cycle event pulses from an I2C master's transfer engine and holds them as sticky status flags. Software sees the flags through a small register port, where it can acknowledge them, and it controls which flags may raise the interrupt line. The mask is never written directly. Two write-only ports change it instead: one turns mask bits on and the other turns them off. A read-only view shows the current mask.

All four registers use one shared bit layout. Every input pulse and every write data word also uses this layout, so a handler can write back the status value it just read and acknowledge exactly those events. The block drives a level interrupt whenever an unmasked flag is pending. It also drives a summary flag for the error sources.

Top module: `irq_event_unit`

## Requirements
- R1: After reset, every status bit and every mask bit is 0. `irq_o` and `err_o` are low.
- R2: An event pulse on `evt_in[k]` sets status bit k at the next clock edge. The bit then stays set until it is cleared by software. Valid positions are: 0 done, 1 FIFO level, 2 no-acknowledge, 3 timeout, 4 target ready, 5 receive overrun, 6 transmit overrun, 7 receive underrun, 9 lost arbitration.
- R3: A write with `reg_sel` = 0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit remains set.
- R5: A write with `reg_sel` = 2 (unmask port) sets each mask bit whose data bit is 1. The other mask bits are unchanged.
- R6: A write with `reg_sel` = 3 (mask-off port) clears each mask bit whose data bit is 1. The other mask bits are unchanged.
- R7: Reads with `reg_sel` = 0 return the status, and reads with `reg_sel` = 1 return the mask. Reads with `reg_sel` = 2 or 3 return 0. A write with `reg_sel` = 1 changes nothing.
- R8: `irq_o` is high exactly when some status bit is set and its mask bit is also set.
- R9: Bit 8 and all bits above 9 always read as 0 in both status and mask, whatever the events or writes.
- R10: `err_o` is high exactly when any of status bits 2, 5, 6, 7 or 9 is set. The mask has no effect on `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | DATA_W | Event pulses in register bit layout |
| reg_sel | input | 2 | Register select: 0 status, 1 mask view, 2 unmask, 3 mask-off |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Level interrupt from masked status |
| err_o | output | 1 | Any error-group status bit pending |

## Verification
The embedded properties check the following on every cycle: that an event always lands in status, that an acknowledge write leaves no targeted bit set unless a new event arrived with it, that the mask moves in the direction of the port that was written, and that unused positions stay zero. Some behaviours can only be shown by the bench's scenarios, because they depend on sequences of operations. These are: the same-cycle race between an event and its acknowledge, writes to the read-only mask view having no effect, the zero readback of the write-only ports, and the irq and error outputs following long random mixes of events and mask changes.

// File: rtl/irq_event_unit.sv
module irq_event_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_in,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'(10'h2FF);
  localparam logic [DATA_W-1:0] ERR_MASK = DATA_W'(10'h2E4);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_SET  = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  logic [DATA_W-1:0] stat_q, mask_q, ack_bits;
  logic wr_set, wr_clr;

  assign ack_bits = (reg_wr && reg_sel == SEL_STAT) ? reg_wdata : '0;
  assign wr_set   = reg_wr && reg_sel == SEL_SET;
  assign wr_clr   = reg_wr && reg_sel == SEL_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~ack_bits) | evt_in) & SRC_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_set) mask_q <= mask_q | (reg_wdata & SRC_MASK);
    else if (wr_clr) mask_q <= mask_q & ~reg_wdata;
  end

  assign reg_rdata = (reg_sel == SEL_STAT) ? stat_q :
                     (reg_sel == SEL_MASK) ? mask_q : '0;
  assign irq_o = |(stat_q & mask_q);
  assign err_o = |(stat_q & ERR_MASK);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & SRC_MASK)) |=> ((($past(evt_in) & SRC_MASK) & ~stat_q) == '0));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STAT) |=> ((stat_q & $past(reg_wdata & ~evt_in)) == '0));

  assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((($past(reg_wdata) & SRC_MASK) & ~mask_q) == '0));

  assert_maskoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(reg_wdata)) == '0));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | mask_q) & ~SRC_MASK) == '0);
endmodule

// File: tb/tb_irq_event_unit.sv
module tb_irq_event_unit;
  localparam int W = 16;
  localparam logic [W-1:0] SRC = 16'h02FF;
  localparam logic [W-1:0] ERR = 16'h02E4;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] evt_in = '0, reg_wdata = '0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 0;
  logic [W-1:0] reg_rdata;
  logic irq_o, err_o;
  logic [W-1:0] m_stat, m_mask;
  int tests = 0, fails = 0;

  irq_event_unit #(.DATA_W(W)) dut (.*);

  always #4 clk = ~clk;

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [W-1:0] nx_stat(logic [W-1:0] s, logic [1:0] sel, logic wr,
                                           logic [W-1:0] wd, logic [W-1:0] ev);
    logic [W-1:0] a = (wr && sel == 2'd0) ? wd : '0;
    return ((s & ~a) | ev) & SRC;
  endfunction

  function automatic logic [W-1:0] nx_mask(logic [W-1:0] m, logic [1:0] sel, logic wr,
                                           logic [W-1:0] wd);
    if (wr && sel == 2'd2) return m | (wd & SRC);
    if (wr && sel == 2'd3) return m & ~wd;
    return m;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] sel, logic wr, logic [W-1:0] wd, logic [W-1:0] ev);
    reg_sel = sel; reg_wr = wr; reg_wdata = wd; evt_in = ev;
    @(posedge clk);
    m_stat = nx_stat(m_stat, sel, wr, wd, ev);
    m_mask = nx_mask(m_mask, sel, wr, wd);
    @(negedge clk);
    reg_wr = 0; evt_in = '0; reg_wdata = '0;
  endtask

  task automatic check_all(string req);
    reg_sel = 2'd0; #1; chk({req, " status"}, reg_rdata, m_stat);
    reg_sel = 2'd1; #1; chk({req, " mask"}, reg_rdata, m_mask);
    reg_sel = 2'd2; #1; chk({req, " R7 unmask read"}, reg_rdata, '0);
    reg_sel = 2'd3; #1; chk({req, " R7 maskoff read"}, reg_rdata, '0);
    chk({req, " R8 irq"}, W'(irq_o), W'(|(m_stat & m_mask)));
    chk({req, " R10 err"}, W'(err_o), W'(|(m_stat & ERR)));
  endtask

  initial begin
    m_stat = '0; m_mask = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    step(2'd1, 0, '0, 16'h0201);            check_all("R2 event set");
    step(2'd1, 0, '0, '0);                  check_all("R2 sticky");
    step(2'd2, 1, 16'h0001, '0);            check_all("R5 unmask bit0 R8");
    step(2'd0, 1, 16'h0001, '0);            check_all("R3 ack bit0 only");
    step(2'd0, 1, 16'h0200, 16'h0200);      check_all("R4 event beats ack");
    step(2'd0, 1, 16'h0200, '0);            check_all("R3 ack lost-arb");
    step(2'd3, 1, 16'h0001, '0);            check_all("R6 mask off");
    step(2'd1, 1, 16'hFFFF, '0);            check_all("R7 mask view write ignored");
    step(2'd2, 1, 16'hFFFF, 16'hFD00);      check_all("R9 unused bits");
    step(2'd3, 1, 16'h0004, 16'h0004);      check_all("R10 err unmasked");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] wd, ev;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      wd  = W'($urandom);
      ev  = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
      step(sel, 1'($urandom_range(0, 1)), wd, ev);
      check_all("R2 R3 R4 R5 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule